// File: doc/BRIEF.md
# Memory Pattern Test Sequencer

A synchronous controller that exercises an external random-access memory with a fixed set of data patterns. Each pass writes one pattern to every address in ascending order. Then it reads every address back, again in ascending order, and compares each word with the value it wrote. Four passes run back to back. The block drives the memory's address, write data and an active-low write strobe, and it samples the memory's read data.

Write timing uses three parameters, each counted in clock cycles with a minimum of one:
- a setup time with the strobe high,
- a low-pulse width,
- a read settle time.

The block keeps the first mismatch it finds (address, expected word and actual word) and raises a sticky error flag. It does not stop on an error: the remaining passes still run. A one-cycle done pulse marks the end of the run.

Top module: `mem_pattern_tester`

## Requirements
- R1: During reset, and after it until a run starts, `busy_o`, `done_o` and `err_o` are 0, `mem_we_no` is 1, and `mem_addr_o` is 0.
- R2: Each write step holds the address and write data for SETUP_CYC cycles with the strobe high. It then drives the strobe low for LOW_CYC cycles, then high for one more cycle, and only then moves to the next address. Addresses go from 0 up to 2**ADDR_W-1.
- R3: After the last write of a pass, every address from 0 upward is presented for SETTLE_CYC cycles with the strobe high. Read data is sampled on the clock edge that ends that window.
- R4: Pass k writes pattern k, with passes in this order:
  - pass 0: all zeros;
  - pass 1: all ones;
  - pass 2: 0x55 repeated at even addresses and 0xAA repeated at odd addresses;
  - pass 3: the address, zero-extended or truncated to DATA_W.
- R5: While the strobe is low, and on the cycle that follows, the address and write data do not change.
- R6: On the first mismatch of a run, `err_o` rises on the cycle after the sampling edge. `fail_addr_o`, `fail_exp_o` and `fail_act_o` take the failing address, the expected word and the actual word. Later mismatches change none of them.
- R7: A mismatch does not shorten the run: all four passes complete, with the same cycle count as a clean run.
- R8: `start_i` starts a run only while `busy_o` is 0. A start pulse during a run has no effect on the sequence.
- R9: `done_o` is 1 for exactly one cycle, starting the cycle after the final read sample. `busy_o` falls in that same cycle.
- R10: Starting a run clears `err_o` and the captured failure fields on the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, honoured only while idle |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_no | output | 1 | Write strobe, active low; the memory captures on its rising edge |
| mem_rdata_i | input | DATA_W | Memory read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse when the run has ended |
| err_o | output | 1 | Sticky mismatch flag |
| fail_addr_o | output | ADDR_W | Address of the first mismatch |
| fail_exp_o | output | DATA_W | Expected word at the first mismatch |
| fail_act_o | output | DATA_W | Word read at the first mismatch |

## Verification
A start sampled on edge E0 puts the first write address on the bus right after E0. From there:
- each write takes SETUP_CYC + LOW_CYC + 1 cycles;
- each read takes SETTLE_CYC cycles;
- an error shows one cycle after the edge that closes the read window of the failing address;
- `done_o` appears one cycle after the last read edge.

The bench turns these counts into a queue holding one expected entry per cycle. It compares the outputs against that queue at every falling edge. Checks are therefore never taken in the cycle where a registered output is still changing.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSET,
    ST_WLOW,
    ST_WREC,
    ST_RSET
  } mpt_state_e;

  localparam int unsigned NUM_PASSES = 4;
  localparam int unsigned PASS_W     = 2;
endpackage

// File: rtl/mpt_pattern_gen.sv
module mpt_pattern_gen #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [mpt_pkg::PASS_W-1:0] pass_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic [DATA_W-1:0]          data_o
);
  logic [DATA_W-1:0] alt_even;
  logic [DATA_W-1:0] addr_ext;

  for (genvar b = 0; b < DATA_W; b++) begin : g_alt
    assign alt_even[b] = ((b % 2) == 0);
  end

  if (DATA_W > ADDR_W) begin : g_pad
    assign addr_ext = {{(DATA_W-ADDR_W){1'b0}}, addr_i};
  end else begin : g_trunc
    assign addr_ext = addr_i[DATA_W-1:0];
  end

  always_comb begin
    unique case (pass_i)
      2'd0:    data_o = '0;
      2'd1:    data_o = '1;
      2'd2:    data_o = addr_i[0] ? ~alt_even : alt_even;
      default: data_o = addr_ext;
    endcase
  end
endmodule

// File: rtl/mpt_step_timer.sv
module mpt_step_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == limit_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (last_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2, R3: step windows never overrun their programmed length
  p_cnt_in_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));
  p_cnt_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i) |=> (cnt_q == '0));
endmodule

// File: rtl/mpt_fail_capture.sv
module mpt_fail_capture #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              chk_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] act_i,
  output logic              err_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  logic hit;
  assign hit = chk_i && (exp_i != act_i) && !err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o       <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
    end else if (clr_i) begin
      err_o       <= 1'b0;
      fail_addr_o <= '0;
      fail_exp_o  <= '0;
      fail_act_o  <= '0;
    end else if (hit) begin
      err_o       <= 1'b1;
      fail_addr_o <= addr_i;
      fail_exp_o  <= exp_i;
      fail_act_o  <= act_i;
    end
  end

  p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> err_o);
  p_capture_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !clr_i) |=> ($stable(fail_addr_o) && $stable(fail_exp_o) && $stable(fail_act_o)));
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!err_o && fail_addr_o == '0));
endmodule

// File: rtl/mem_pattern_tester.sv
module mem_pattern_tester #(
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned SETUP_CYC  = 2,
  parameter int unsigned LOW_CYC    = 2,
  parameter int unsigned SETTLE_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_no,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] fail_addr_o,
  output logic [DATA_W-1:0] fail_exp_o,
  output logic [DATA_W-1:0] fail_act_o
);
  import mpt_pkg::*;

  localparam int unsigned MAX_A   = (SETUP_CYC > LOW_CYC) ? SETUP_CYC : LOW_CYC;
  localparam int unsigned MAX_CYC = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASSES - 1);

  mpt_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PASS_W-1:0] pass_q;
  logic              done_q;
  logic [CNT_W-1:0]  limit;
  logic              step_last;
  logic              launch;
  logic              chk;
  logic              at_last_addr;
  logic [DATA_W-1:0] pat;

  assign launch       = start_i && (state_q == ST_IDLE);
  assign at_last_addr = (addr_q == LAST_ADDR);
  assign chk          = (state_q == ST_RSET) && step_last;

  always_comb begin
    unique case (state_q)
      ST_WSET: limit = CNT_W'(SETUP_CYC);
      ST_WLOW: limit = CNT_W'(LOW_CYC);
      ST_RSET: limit = CNT_W'(SETTLE_CYC);
      default: limit = CNT_W'(1);
    endcase
  end

  mpt_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (state_q != ST_IDLE),
    .limit_i(limit),
    .last_o (step_last)
  );

  mpt_pattern_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pat (
    .pass_i(pass_q),
    .addr_i(addr_q),
    .data_o(pat)
  );

  mpt_fail_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (launch),
    .chk_i      (chk),
    .addr_i     (addr_q),
    .exp_i      (pat),
    .act_i      (mem_rdata_i),
    .err_o      (err_o),
    .fail_addr_o(fail_addr_o),
    .fail_exp_o (fail_exp_o),
    .fail_act_o (fail_act_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pass_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (launch) begin
          state_q <= ST_WSET;
          addr_q  <= '0;
          pass_q  <= '0;
        end
        ST_WSET: if (step_last) state_q <= ST_WLOW;
        ST_WLOW: if (step_last) state_q <= ST_WREC;
        ST_WREC: begin
          // strobe is back high here; only now may the address move
          if (at_last_addr) begin
            addr_q  <= '0;
            state_q <= ST_RSET;
          end else begin
            addr_q  <= addr_q + ADDR_W'(1);
            state_q <= ST_WSET;
          end
        end
        ST_RSET: if (step_last) begin
          if (!at_last_addr) begin
            addr_q <= addr_q + ADDR_W'(1);
          end else if (pass_q == LAST_PASS) begin
            addr_q  <= '0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            addr_q  <= '0;
            pass_q  <= pass_q + PASS_W'(1);
            state_q <= ST_WSET;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = pat;
  assign mem_we_no   = (state_q != ST_WLOW);
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;

  p_addr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_no) |=> ($stable(mem_addr_o) && $stable(mem_wdata_o)));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_launch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && mem_addr_o == '0 && mem_we_no));
  p_read_no_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk |-> mem_we_no);
endmodule

// File: tb/mem_pattern_tester_test.sv
module mem_pattern_tester_test;
  localparam int AW = 4, DW = 8, SU = 2, LO = 2, ST = 2;
  localparam int DEPTH = 1 << AW;
  localparam int MASK  = (1 << DW) - 1;
  localparam int FA = 5, FB = 3;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [AW-1:0] mem_addr_o, fail_addr_o;
  logic [DW-1:0] mem_wdata_o, mem_rdata_i, fail_exp_o, fail_act_o;
  logic mem_we_no, busy_o, done_o, err_o;

  int tests = 0, fails = 0;
  bit fault_on = 0;
  logic [DW-1:0] mem [DEPTH];

  always #2 clk = ~clk;

  mem_pattern_tester #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .LOW_CYC(LO),
                       .SETTLE_CYC(ST)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_no(mem_we_no),
    .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .fail_addr_o(fail_addr_o), .fail_exp_o(fail_exp_o), .fail_act_o(fail_act_o));

  // behavioural memory: capture on rising strobe, one stuck-at-1 bit when enabled
  always @(posedge mem_we_no) if (rst_ni) mem[mem_addr_o] <= mem_wdata_o;
  assign mem_rdata_i = mem[mem_addr_o] |
                       ((fault_on && int'(mem_addr_o) == FA) ? DW'(1 << FB) : DW'(0));

  int q_addr[$], q_wd[$], q_we[$], q_err[$];
  string q_req[$];
  bit m_err; int m_fa, m_fe, m_fx;

  function automatic int pat(int p, int a);
    case (p)
      0: return 0;
      1: return MASK;
      2: return (a % 2) ? ('hAAAA & MASK) : ('h5555 & MASK);
      default: return a & MASK;
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(int a, int wd, int we, string req);
    q_addr.push_back(a); q_wd.push_back(wd); q_we.push_back(we);
    q_err.push_back(m_err); q_req.push_back(req);
  endtask

  task automatic build();
    q_addr.delete(); q_wd.delete(); q_we.delete(); q_err.delete(); q_req.delete();
    m_err = 0; m_fa = 0; m_fe = 0; m_fx = 0;
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        repeat (SU) push(a, pat(p, a), 1, "R2");
        repeat (LO) push(a, pat(p, a), 0, "R2");
        push(a, pat(p, a), 1, "R5");
      end
      for (int a = 0; a < DEPTH; a++) begin
        int act;
        repeat (ST) push(a, -1, 1, "R3");
        act = pat(p, a) | ((fault_on && a == FA) ? (1 << FB) : 0);
        if (act != pat(p, a) && !m_err) begin
          m_err = 1; m_fa = a; m_fe = pat(p, a); m_fx = act;
        end
      end
    end
  endtask

  task automatic run(int inject);
    build();
    @(negedge clk); start_i = 1'b1;
    foreach (q_addr[i]) begin
      @(negedge clk);
      start_i = (i == inject);
      check(q_req[i], "addr", int'(mem_addr_o), q_addr[i]);
      check(q_req[i], "strobe", int'(mem_we_no), q_we[i]);
      if (q_wd[i] >= 0) check("R4", "wdata", int'(mem_wdata_o), q_wd[i]);
      check("R8", "busy", int'(busy_o), 1);
      check("R9", "done_early", int'(done_o), 0);
      check("R6", "err", int'(err_o), q_err[i]);
    end
    @(negedge clk); start_i = 1'b0;
    check("R9", "done", int'(done_o), 1);
    check("R9", "busy_fall", int'(busy_o), 0);
    check("R7", "err_end", int'(err_o), m_err);
    if (m_err) begin
      check("R6", "fail_addr", int'(fail_addr_o), m_fa);
      check("R6", "fail_exp", int'(fail_exp_o), m_fe);
      check("R6", "fail_act", int'(fail_act_o), m_fx);
    end
    @(negedge clk);
    check("R9", "done_single", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy_rst", int'(busy_o), 0);
    check("R1", "strobe_rst", int'(mem_we_no), 1);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", "busy", int'(busy_o), 0);
    check("R1", "done", int'(done_o), 0);
    check("R1", "err", int'(err_o), 0);
    check("R1", "strobe", int'(mem_we_no), 1);
    check("R1", "addr", int'(mem_addr_o), 0);

    run(100);                 // R8: start pulse mid-run ignored
    for (int a = 0; a < DEPTH; a++) check("R4", "mem_final", int'(mem[a]), a & MASK);

    fault_on = 1;
    run(-1);                  // R6, R7: stuck bit found, run completes
    check("R6", "fail_addr_5", int'(fail_addr_o), FA);
    check("R6", "fail_exp_0", int'(fail_exp_o), 0);
    check("R6", "fail_act_8", int'(fail_act_o), 1 << FB);
    repeat (5) @(negedge clk);
    check("R6", "err_held_idle", int'(err_o), 1);

    fault_on = 0;
    run(-1);                  // R10: start clears error
    check("R10", "err_cleared", int'(err_o), 0);
    check("R10", "fail_addr_cleared", int'(fail_addr_o), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule